// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Rule Monitor

This block sits beside the command bus of a four-bank DDR SDRAM and watches it passively. It samples the strobes on every rising clock edge and recognises five commands: activate, read, write, precharge and no-operation. It records which banks hold an open row and counts the cycles since each bank, and the bus as a whole, last saw an activate. Whenever a command breaks one of the bank rules, one of five error outputs pulses for one cycle.

The spacing limits are parameters counted in clock cycles. These are the row-to-column delay, the activate-to-activate delay across banks, and the row cycle time for the same bank. The burst length code is the only mode setting the monitor takes in. It uses that code to decide when a write with auto precharge has finished and its bank has closed. The monitor never drives the memory bus. It is meant for simulation benches and for on-chip checking of a memory controller.

Top module: `ddr_bank_rule_monitor`

## Requirements
- R1: Pins are sampled only at rising edges. Each error output is a register that goes high for exactly one cycle, just after the edge that carried the offending command. A cycle with cs_n high, or with any strobe pattern other than the five commands, changes neither the flags nor the bank state.
- R2: With cs_n low, the pattern {ras_n,cas_n,we_n} = 3'b011 is an activate. It opens the bank selected by `ba` and restarts that bank's cycle counter.
- R3: Read is 3'b101 and write is 3'b100. Either one reaching an open bank fewer than T_RCD cycles after that bank's activate raises `err_rcd`.
- R4: A read or write reaching a closed bank raises `err_closed`. No row-to-column check is made for it.
- R5: An activate to a bank that is already open raises `err_open`.
- R6: An activate to a bank other than the one in the previous activate raises `err_rrd` when it comes fewer than T_RRD cycles after that previous activate.
- R7: An activate to a bank fewer than T_RC cycles after that same bank's previous activate raises `err_rc`. This holds even if the bank was precharged in between.
- R8: Precharge is 3'b010. With `ap` high it closes all four banks; with `ap` low it closes only bank `ba`.
- R9: A write to an open bank with `ap` high closes that bank after N cycles. N is 1, 2 or 4 for `burst_code` 2'b01, 2'b10 or 2'b11, and 1 for 2'b00. The bank still counts as open at the edge N cycles after the write, and as closed from the edge after that.
- R10: After reset all banks are closed, all counters are saturated and all flags are low, so the first activate to any bank is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| burst_code | input | 2 | Burst length code: 01=2, 10=4, 11=8 beats |
| err_rcd | output | 1 | Column command came too soon after activate |
| err_closed | output | 1 | Column command to a closed bank |
| err_open | output | 1 | Activate to an open bank |
| err_rrd | output | 1 | Cross-bank activate spacing too short |
| err_rc | output | 1 | Same-bank activate spacing too short |

## Verification
A wrong open/closed bit for a bank first shows at the ports as a false or missing `err_closed` or `err_open`. That happens one cycle after the next read, write or activate to that bank, so the sweeps follow every state change with such a command. A counter that is off by one cycle shows only at the exact boundary gap. For this reason the gap between two commands is swept through every value from 1 to just past each limit, for every pair of banks. Auto-precharge timing is probed by reading the bank at every delay around the closing edge, for each burst code.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_OTHER
  } cmd_e;

  // Strobe pattern {ras_n,cas_n,we_n} with chip select low.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = CMD_NOP;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        default: c = CMD_OTHER;
      endcase
    end
    return c;
  endfunction

  // Clock cycles a write burst occupies (two beats per clock).
  function automatic logic [3:0] burst_clocks(input logic [1:0] code);
    logic [3:0] n;
    case (code)
      2'b10:   n = 4'd2;
      2'b11:   n = 4'd4;
      default: n = 4'd1;
    endcase
    return n;
  endfunction

  // Saturating increment used by every spacing counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic is_act,
  output logic is_rd,
  output logic is_wr,
  output logic is_pre
);
  cmd_e cmd;

  always_comb begin
    cmd    = decode_cmd(cs_n, ras_n, cas_n, we_n);
    is_act = (cmd == CMD_ACT);
    is_rd  = (cmd == CMD_RD);
    is_wr  = (cmd == CMD_WR);
    is_pre = (cmd == CMD_PRE);
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_mon_pkg::*;
#(
  parameter int CW   = 3,
  parameter int CMAX = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic          wr_ap_i,
  input  logic [3:0]    burst_clks_i,
  output logic          open_o,
  output logic [CW-1:0] since_o
);
  localparam logic [CW-1:0] SAT = CW'(CMAX);

  logic [3:0] ap_left;
  logic       ap_expire;

  assign ap_expire = (ap_left == 4'd1) && !act_i && !pre_i && !wr_ap_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o  <= 1'b0;
      since_o <= SAT;
      ap_left <= '0;
    end else begin
      since_o <= act_i ? CW'(1) : CW'(sat_inc(int'(since_o), CMAX));
      if (act_i) begin
        open_o  <= 1'b1;
        ap_left <= '0;
      end else if (pre_i) begin
        open_o  <= 1'b0;
        ap_left <= '0;
      end else if (wr_ap_i) begin
        ap_left <= burst_clks_i;
      end else if (ap_expire) begin
        open_o  <= 1'b0;
        ap_left <= '0;
      end else if (ap_left != 4'd0) begin
        ap_left <= ap_left - 4'd1;
      end
    end
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (open_o && since_o == CW'(1))); // R2
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && !act_i) |=> !open_o); // R8
  AST_AP_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ap_expire |=> !open_o); // R9
  AST_AP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_left > 4'd1 && open_o && !pre_i) |=> open_o); // R9
endmodule

// File: rtl/ddr_act_spacing.sv
module ddr_act_spacing
  import ddr_mon_pkg::*;
#(
  parameter int CW   = 3,
  parameter int CMAX = 7,
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic [BA_W-1:0] bank_i,
  output logic [CW-1:0]   gap_o,
  output logic [BA_W-1:0] last_bank_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_o       <= CW'(CMAX);
      last_bank_o <= '0;
    end else if (act_i) begin
      gap_o       <= CW'(1);
      last_bank_o <= bank_i;
    end else begin
      gap_o <= CW'(sat_inc(int'(gap_o), CMAX));
    end
  end

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (gap_o == CW'(1) && last_bank_o == $past(bank_i))); // R6
endmodule

// File: rtl/ddr_bank_rule_monitor.sv
module ddr_bank_rule_monitor
  import ddr_mon_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_RC  = 7,
  parameter int BA_W  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       ap,
  input  logic [1:0] burst_code,
  output logic       err_rcd,
  output logic       err_closed,
  output logic       err_open,
  output logic       err_rrd,
  output logic       err_rc
);
  localparam int NBANK = 1 << BA_W;
  localparam int CMAX  = (T_RC > T_RCD) ? ((T_RC > T_RRD) ? T_RC : T_RRD)
                                        : ((T_RCD > T_RRD) ? T_RCD : T_RRD);
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LIM_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] LIM_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] LIM_RC  = CW'(T_RC);

  logic            is_act, is_rd, is_wr, is_pre, is_col;
  logic [NBANK-1:0] open_vec;
  logic [CW-1:0]   since_arr [NBANK];
  logic [CW-1:0]   gap;
  logic [BA_W-1:0] last_bank;
  logic [3:0]      burst_clks;
  logic            cur_open;
  logic [CW-1:0]   cur_since;

  // Named rule events, one per flag.
  logic ev_rcd, ev_closed, ev_open, ev_rrd, ev_rc;

  ddr_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .is_act(is_act), .is_rd(is_rd), .is_wr(is_wr), .is_pre(is_pre)
  );

  assign burst_clks = burst_clocks(burst_code);
  assign is_col     = is_rd || is_wr;
  assign cur_open   = open_vec[ba];
  assign cur_since  = since_arr[ba];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(b));
    ddr_bank_tracker #(.CW(CW), .CMAX(CMAX)) u_trk (
      .clk(clk), .rst_n(rst_n),
      .act_i(is_act && hit),
      .pre_i(is_pre && (ap || hit)),
      .wr_ap_i(is_wr && ap && hit && open_vec[b]),
      .burst_clks_i(burst_clks),
      .open_o(open_vec[b]),
      .since_o(since_arr[b])
    );
  end

  ddr_act_spacing #(.CW(CW), .CMAX(CMAX), .BA_W(BA_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .act_i(is_act), .bank_i(ba),
    .gap_o(gap), .last_bank_o(last_bank)
  );

  assign ev_closed = is_col && !cur_open;
  assign ev_rcd    = is_col && cur_open && (cur_since < LIM_RCD);
  assign ev_open   = is_act && cur_open;
  assign ev_rc     = is_act && (cur_since < LIM_RC);
  assign ev_rrd    = is_act && (last_bank != ba) && (gap < LIM_RRD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {err_rcd, err_closed, err_open, err_rrd, err_rc} <= '0;
    end else begin
      err_rcd    <= ev_rcd;
      err_closed <= ev_closed;
      err_open   <= ev_open;
      err_rrd    <= ev_rrd;
      err_rc     <= ev_rc;
    end
  end

  AST_QUIET_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_act || is_col) |=> !(err_rcd || err_closed || err_open || err_rrd || err_rc)); // R1
  AST_RCD_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_rcd |-> $past(is_col && cur_open)); // R3
  AST_CLOSED_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    err_closed |-> !err_rcd); // R4
  AST_OPEN_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    err_open |-> $past(is_act)); // R5
  AST_RRD_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    err_rrd |-> $past(is_act && last_bank != ba)); // R6
  AST_RC_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    err_rc |-> $past(is_act)); // R7
endmodule

// File: tb/ddr_bank_rule_monitor_tb.sv
module ddr_bank_rule_monitor_tb;
  localparam int T_RCD = 3;
  localparam int T_RRD = 2;
  localparam int T_RC  = 7;

  // Bench command codes
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4;
  localparam int C_O000 = 5, C_O001 = 6, C_O110 = 7, C_DESEL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic ap = 1'b0;
  logic [1:0] burst_code = 2'b01;
  logic err_rcd, err_closed, err_open, err_rrd, err_rc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // Reference model state
  bit m_open  [4];
  bit m_armed [4];
  int m_close [4];
  int m_act_t [4];
  int m_last_t;
  int m_last_b;

  always #2.5 clk = ~clk;

  ddr_bank_rule_monitor #(.T_RCD(T_RCD), .T_RRD(T_RRD), .T_RC(T_RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .ap(ap), .burst_code(burst_code),
    .err_rcd(err_rcd), .err_closed(err_closed), .err_open(err_open),
    .err_rrd(err_rrd), .err_rc(err_rc)
  );

  function automatic int clocks_of(input int code);
    if (code == 2) return 2;
    if (code == 3) return 4;
    return 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_armed[i] = 0; m_close[i] = 0; m_act_t[i] = -1000;
    end
    m_last_t = -1000;
    m_last_b = 0;
  endtask

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: flags {rcd,closed,open,rrd,rc} got %b expected %b at cycle %0d",
               tag, got, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    check("R10", {err_rcd, err_closed, err_open, err_rrd, err_rc}, 5'b0);
  endtask

  task automatic issue(input int cmd, input int b, input bit apb, input int code, input string tag);
    logic [4:0] exp;
    int t;
    @(negedge clk);
    ba = 2'(b); ap = apb; burst_code = 2'(code);
    case (cmd)
      C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      C_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      C_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      C_O000:  {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      C_O001:  {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      C_O110:  {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      C_DESEL: {cs_n, ras_n, cas_n, we_n} = 4'b1011;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
    @(posedge clk);
    cyc++;
    t = cyc;
    exp = '0;
    for (int i = 0; i < 4; i++)
      if (m_armed[i] && t > m_close[i]) begin m_open[i] = 0; m_armed[i] = 0; end
    if (cmd == C_ACT) begin
      exp[2] = m_open[b];
      exp[0] = (t - m_act_t[b]) < T_RC;
      exp[1] = (m_last_b != b) && ((t - m_last_t) < T_RRD);
      m_open[b] = 1; m_armed[b] = 0; m_act_t[b] = t; m_last_t = t; m_last_b = b;
    end else if (cmd == C_RD || cmd == C_WR) begin
      if (!m_open[b]) exp[3] = 1;
      else begin
        exp[4] = (t - m_act_t[b]) < T_RCD;
        if (cmd == C_WR && apb) begin m_armed[b] = 1; m_close[b] = t + clocks_of(code); end
      end
    end else if (cmd == C_PRE) begin
      for (int i = 0; i < 4; i++)
        if (apb || i == b) begin m_open[i] = 0; m_armed[i] = 0; end
    end
    #1;
    check(tag, {err_rcd, err_closed, err_open, err_rrd, err_rc}, exp);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(C_NOP, 0, 0, 1, "R1");
  endtask

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    // R10: first activate after reset is legal for every bank
    for (int b = 0; b < 4; b++) begin
      do_reset();
      issue(C_ACT, b, 0, 1, "R10");
    end

    // R5 R6 R7 sweep over all bank pairs and gaps
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int g = 1; g <= T_RC + 1; g++) begin
          do_reset();
          issue(C_ACT, a, 0, 1, "R2");
          for (int k = 1; k < g; k++) begin
            if (k == 1 && a == b) issue(C_PRE, a, 0, 1, "R8");
            else issue(C_NOP, 0, 0, 1, "R1");
          end
          issue(C_ACT, b, 0, 1, (a == b) ? "R7" : "R6");
        end

    // R3 row-to-column sweep, reads and writes
    for (int b = 0; b < 4; b++)
      for (int g = 1; g <= T_RCD + 2; g++)
        for (int w = 0; w < 2; w++) begin
          do_reset();
          issue(C_ACT, b, 0, 1, "R2");
          nops(g - 1);
          issue(w ? C_WR : C_RD, b, 0, 1, "R3");
        end

    // R4 closed bank access; R8 precharge single and all
    do_reset();
    issue(C_RD, 2, 0, 1, "R4");
    issue(C_WR, 3, 0, 1, "R4");
    issue(C_ACT, 0, 0, 1, "R2");
    nops(2);
    issue(C_ACT, 1, 0, 1, "R2");
    nops(T_RCD);
    issue(C_PRE, 0, 0, 1, "R8");
    issue(C_RD, 1, 0, 1, "R8");
    issue(C_RD, 0, 0, 1, "R8");
    issue(C_PRE, 3, 1, 1, "R8");
    issue(C_WR, 1, 0, 1, "R8");
    issue(C_ACT, 1, 0, 1, "R8");

    // R9 auto-precharge write closes after the burst, every code and delay
    for (int code = 0; code < 4; code++)
      for (int d = 0; d <= 5; d++) begin
        do_reset();
        issue(C_ACT, 1, 0, 1, "R2");
        nops(T_RCD);
        issue(C_WR, 1, 1, code, "R9");
        nops(d);
        issue(C_RD, 1, 0, 1, "R9");
      end
    // Write with ap to a closed bank arms nothing
    do_reset();
    issue(C_WR, 2, 1, 3, "R4");
    issue(C_ACT, 2, 0, 1, "R9");

    // R1 ignored patterns leave flags and bank state untouched
    do_reset();
    issue(C_ACT, 0, 0, 1, "R2");
    nops(T_RC);
    issue(C_DESEL, 1, 0, 1, "R1");
    issue(C_O000, 1, 1, 1, "R1");
    issue(C_O001, 0, 1, 1, "R1");
    issue(C_O110, 0, 1, 1, "R1");
    issue(C_RD, 0, 0, 1, "R1");
    issue(C_ACT, 1, 0, 1, "R1");
    issue(C_ACT, 0, 0, 1, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule